// File: doc/BRIEF.md
# Dual-Lane Byte/Word Data Memory

This block is the data store of a 16-bit core. Every word is held as two byte-wide lanes that share one word index but have their own write strobes, so a single store can update one byte or both. Effective addresses are byte-granular and 16 bits wide. Only a window of the 64 KB space is backed by storage: it starts at the even byte address `BASE` and holds `DEPTH` words. Any other address is unimplemented.

Two read ports look into the same storage. The X port carries loads and stores of either size. A byte load fetches the containing word and returns the chosen byte in the low eight bits of the read data. The Y port is a word-only read port that feeds multiply-accumulate operands. Both ports are synchronous: results appear on the clock edge that takes the request. Unimplemented addresses read as zero, drop stores, and raise an error flag.

Top module: `dual_lane_dmem`

## Requirements
- R1: While `rst_n` is low, `x_rdata`, `y_rdata` and `addr_err` are zero from the next rising edge.
- R2: A word read on X (`x_en`=1, `x_we`=0, `x_byte`=0) at an implemented address returns the full word with index `(x_addr-BASE)>>1` on `x_rdata` one clock later, and `x_addr[0]` has no effect.
- R3: A byte read on X (`x_byte`=1) returns bits [7:0] of the stored word when `x_addr[0]`=0 and bits [15:8] when `x_addr[0]`=1. The byte is placed on `x_rdata[7:0]` and `x_rdata[15:8]` is zero.
- R4: A byte write (`x_we`=1, `x_byte`=1) stores `x_wdata[7:0]` into the low lane when `x_addr[0]`=0 or the high lane when `x_addr[0]`=1. The other lane keeps its contents.
- R5: A word write stores all of `x_wdata` into the aligned word, and `x_addr[0]` has no effect.
- R6: A Y read (`y_en`=1) at an implemented address returns the full stored word on `y_rdata` one clock later, and `y_addr[0]` has no effect.
- R7: The implemented window is byte addresses `BASE` to `BASE+2*DEPTH-1`. A read outside it on either port returns 0x0000.
- R8: A write outside the window changes no stored word.
- R9: `addr_err` is high in the cycle after an enabled access on either port to an unimplemented address. Otherwise it is low.
- R10: `x_rdata` holds its value through cycles with no X read (idle or write), and `y_rdata` holds its value while `y_en` is low.
- R11: When an X write and a Y read hit the same word in the same cycle, Y returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the outputs |
| x_en | input | 1 | X port access request |
| x_we | input | 1 | X access is a write |
| x_byte | input | 1 | X access size: 1 byte, 0 word |
| x_addr | input | AW | X byte address |
| x_wdata | input | 16 | X write data (byte writes use bits [7:0]) |
| x_rdata | output | 16 | X read data |
| y_en | input | 1 | Y port word read request |
| y_addr | input | AW | Y byte address |
| y_rdata | output | 16 | Y read data |
| addr_err | output | 1 | Unimplemented address was accessed in the previous cycle |

## Verification
The case that is hardest to reach from the ports is a discarded store that still lands in the array because the word index is cut down to fewer bits. This can only be seen by reading the exact word that an out-of-window address would fold onto. The stimulus writes just above the window and just below `BASE`, and then reads the words those addresses would alias to. A second case that is hard to reach is a Y read of the same word an X store hits in the same cycle. It is forced directly and also arises in the random mix, which keeps most addresses inside a small window.

// File: rtl/dual_lane_dmem.sv
module dual_lane_dmem #(
  parameter int AW    = 16,
  parameter int BASE  = 16'h0800,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_en,
  input  logic          x_we,
  input  logic          x_byte,
  input  logic [AW-1:0] x_addr,
  input  logic [15:0]   x_wdata,
  output logic [15:0]   x_rdata,
  input  logic          y_en,
  input  logic [AW-1:0] y_addr,
  output logic [15:0]   y_rdata,
  output logic          addr_err
);
  localparam int LANES = 2;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [31:0] LO_U = 32'(BASE);
  localparam logic [31:0] HI_U = 32'(BASE + 2*DEPTH);

  function automatic logic in_win(input logic [AW-1:0] a);
    return (32'(a) >= LO_U) && (32'(a) < HI_U);
  endfunction

  function automatic logic [IW-1:0] word_idx(input logic [AW-1:0] a);
    return IW'((a - AW'(BASE)) >> 1);
  endfunction

  logic          x_ok, y_ok;
  logic [IW-1:0] x_idx, y_idx;
  logic [7:0]    x_lane [LANES];
  logic [7:0]    y_lane [LANES];
  logic [15:0]   x_word, y_word;

  assign x_ok  = in_win(x_addr);
  assign y_ok  = in_win(y_addr);
  assign x_idx = word_idx(x_addr);
  assign y_idx = word_idx(y_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic       wr;
    assign wr = x_en && x_we && x_ok && (!x_byte || (x_addr[0] == 1'(l)));
    always_ff @(posedge clk)
      if (wr) mem[x_idx] <= x_byte ? x_wdata[7:0] : x_wdata[l*8 +: 8];
    assign x_lane[l] = mem[x_idx];
    assign y_lane[l] = mem[y_idx];
  end

  assign x_word = {x_lane[1], x_lane[0]};
  assign y_word = {y_lane[1], y_lane[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_rdata  <= '0;
      y_rdata  <= '0;
      addr_err <= 1'b0;
    end else begin
      if (x_en && !x_we)
        x_rdata <= !x_ok  ? 16'h0000 :
                   x_byte ? {8'h00, x_addr[0] ? x_word[15:8] : x_word[7:0]} :
                            x_word;
      if (y_en)
        y_rdata <= y_ok ? y_word : 16'h0000;
      addr_err <= (x_en && !x_ok) || (y_en && !y_ok);
    end
  end
endmodule

// File: rtl/dual_lane_dmem_chk.sv
module dual_lane_dmem_chk #(
  parameter int AW    = 16,
  parameter int BASE  = 16'h0800,
  parameter int DEPTH = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          x_en,
  input logic          x_we,
  input logic          x_byte,
  input logic [AW-1:0] x_addr,
  input logic          y_en,
  input logic [AW-1:0] y_addr,
  input logic [15:0]   x_rdata,
  input logic [15:0]   y_rdata,
  input logic          addr_err
);
  logic x_in, y_in, x_rd;
  assign x_in = ({16'h0, x_addr} >= 32'(BASE)) && ({16'h0, x_addr} < 32'(BASE + 2*DEPTH));
  assign y_in = ({16'h0, y_addr} >= 32'(BASE)) && ({16'h0, y_addr} < 32'(BASE + 2*DEPTH));
  assign x_rd = x_en && !x_we;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (x_rdata == 16'h0 && y_rdata == 16'h0 && !addr_err));
  p_byte_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    x_rd && x_byte |=> x_rdata[15:8] == 8'h00);
  p_x_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    x_rd && !x_in |=> x_rdata == 16'h0);
  p_y_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    y_en && !y_in |=> y_rdata == 16'h0);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_en && !x_in) || (y_en && !y_in) |=> addr_err);
  p_err_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((x_en && !x_in) || (y_en && !y_in)) |=> !addr_err);
  p_x_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !x_rd |=> $stable(x_rdata));
  p_y_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !y_en |=> $stable(y_rdata));
endmodule

bind dual_lane_dmem dual_lane_dmem_chk #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .x_en(x_en), .x_we(x_we), .x_byte(x_byte),
  .x_addr(x_addr), .y_en(y_en), .y_addr(y_addr), .x_rdata(x_rdata),
  .y_rdata(y_rdata), .addr_err(addr_err)
);

// File: tb/dual_lane_dmem_tb.sv
module dual_lane_dmem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int BASE  = 16'h0800;
  localparam int DEPTH = 1024;
  localparam int LIMIT = BASE + 2*DEPTH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic x_en = 0, x_we = 0, x_byte = 0, y_en = 0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic [15:0] x_wdata = '0, x_rdata, y_rdata;
  logic addr_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] model [DEPTH];
  logic [15:0] exp_x = 0, exp_y = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_dmem #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .x_en(x_en), .x_we(x_we), .x_byte(x_byte),
    .x_addr(x_addr), .x_wdata(x_wdata), .x_rdata(x_rdata), .y_en(y_en),
    .y_addr(y_addr), .y_rdata(y_rdata), .addr_err(addr_err));

  function automatic bit f_in(input logic [AW-1:0] a);
    return (int'({16'h0, a}) >= BASE) && (int'({16'h0, a}) < LIMIT);
  endfunction
  function automatic int f_idx(input logic [AW-1:0] a);
    return (int'({16'h0, a}) - BASE) / 2;
  endfunction
  function automatic logic [15:0] f_xread(input logic [AW-1:0] a, input bit b);
    logic [15:0] w;
    if (!f_in(a)) return 16'h0;
    w = model[f_idx(a)];
    if (!b) return w;
    return a[0] ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit en, input bit we, input bit b, input logic [AW-1:0] xa,
                    input logic [15:0] wd, input bit yen, input logic [AW-1:0] ya,
                    input string tx);
    bit exp_e;
    string tagx, tagy;
    tagx = tx;
    if (tagx == "") tagx = (en && !we) ? (f_in(xa) ? (b ? "R3" : "R2") : "R7") : "R10";
    tagy = yen ? (f_in(ya) ? ((en && we && f_in(xa) && f_idx(xa) == f_idx(ya)) ? "R11" : "R6") : "R7") : "R10";
    if (en && !we) exp_x = f_xread(xa, b);
    if (yen) exp_y = f_xread(ya, 1'b0);
    exp_e = (en && !f_in(xa)) || (yen && !f_in(ya));
    if (en && we && f_in(xa)) begin
      if (!b) model[f_idx(xa)] = wd;
      else if (xa[0]) model[f_idx(xa)][15:8] = wd[7:0];
      else model[f_idx(xa)][7:0] = wd[7:0];
    end
    x_en = en; x_we = we; x_byte = b; x_addr = xa; x_wdata = wd; y_en = yen; y_addr = ya;
    @(posedge clk); #1;
    chk(x_rdata == exp_x, tagx, x_rdata, exp_x);
    chk(y_rdata == exp_y, tagy, y_rdata, exp_y);
    chk(addr_err == exp_e, "R9", {15'h0, addr_err}, {15'h0, exp_e});
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    if ($urandom_range(9) < 8) return AW'(BASE + $urandom_range(2*DEPTH - 1));
    return AW'($urandom);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(x_rdata == 0 && y_rdata == 0 && !addr_err, "R1", x_rdata | y_rdata, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      op(1, 1, 0, AW'(BASE + 2*i), 16'(i * 16'h9E37 + 16'h1357), 0, '0, "");
    // R4 byte writes touch one lane
    op(1, 1, 0, AW'(BASE + 4), 16'hA5C3, 0, '0, "");
    op(1, 1, 1, AW'(BASE + 5), 16'h007E, 0, '0, "");
    op(1, 0, 0, AW'(BASE + 4), 16'h0, 0, '0, "R4");
    op(1, 1, 1, AW'(BASE + 4), 16'h1234, 0, '0, "");
    op(1, 0, 0, AW'(BASE + 4), 16'h0, 0, '0, "R4");
    // R5 word write at odd address
    op(1, 1, 0, AW'(BASE + 7), 16'hBEEF, 0, '0, "");
    op(1, 0, 0, AW'(BASE + 6), 16'h0, 1, AW'(BASE + 7), "R5");
    op(1, 0, 0, AW'(BASE + 7), 16'h0, 0, '0, "R2");
    op(1, 0, 1, AW'(BASE + 7), 16'h0, 0, '0, "R3");
    op(1, 0, 1, AW'(BASE + 6), 16'h0, 0, '0, "R3");
    // R8 discarded writes that would alias on a truncated index
    op(1, 1, 0, AW'(LIMIT + 4), 16'h1111, 0, '0, "");
    op(1, 0, 0, AW'(BASE + 4), 16'h0, 0, '0, "R8");
    op(1, 1, 0, AW'(BASE - 2), 16'h2222, 0, '0, "");
    op(1, 0, 0, AW'(LIMIT - 2), 16'h0, 0, '0, "R8");
    // R7 window edges
    op(1, 0, 0, AW'(LIMIT - 1), 16'h0, 1, AW'(LIMIT), "");
    op(1, 0, 0, AW'(BASE - 1), 16'h0, 1, AW'(BASE), "");
    op(1, 0, 1, AW'(LIMIT), 16'h0, 1, AW'(BASE - 1), "R7");
    // R11 same-word write and Y read
    op(1, 1, 0, AW'(BASE + 10), 16'hCAFE, 1, AW'(BASE + 11), "");
    op(0, 0, 0, '0, 16'h0, 1, AW'(BASE + 10), "");
    // R10 idle and write cycles hold read data
    op(0, 0, 0, '0, 16'h0, 0, '0, "R10");
    op(1, 1, 0, AW'(BASE + 12), 16'h5A5A, 0, '0, "R10");
    for (int i = 0; i < 4000; i++) begin
      bit en, we, b, yen;
      logic [AW-1:0] xa, ya;
      en = $urandom_range(9) < 8; we = $urandom_range(2) == 0; b = $urandom_range(1) == 1;
      yen = $urandom_range(3) < 3;
      xa = rnd_addr();
      ya = ($urandom_range(7) == 0) ? xa : rnd_addr();
      op(en, we, b, xa, 16'($urandom), yen, ya, "");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule